// File: doc/BRIEF.md
# LR/SC Exclusive Reservation Monitor

This block holds the single load-reserved reservation of one hart in a 32-bit RISC-V style core and settles the outcome of every store-conditional. The core presents one memory operation per cycle in its address phase (none, load-reserved, store-conditional or plain store, with a byte address). The block answers in that same cycle with a store-enable qualifier. The qualifier stays low for a store-conditional that has no matching reservation, so that store never reaches memory.

One cycle later the bus data phase returns an exclusive-okay flag from the global monitor and a fault flag. A store-conditional writes back a 32-bit status word. That word is 0 when the store took place and 1 when it did not. A success needs both a local reservation on the same word and an exclusive-okay response. Stores seen from other harts through a snoop port drop a matching reservation. The hart's own plain stores never touch it.

A load-reserved followed directly by a store-conditional to the same word is handled by a bypass from the data phase. The bypass is needed because the reservation register is written only at the end of that data phase.

Top module: `lrsc_monitor`

## Requirements
- R1: The write-back word of a store-conditional always has bits 31:1 equal to zero. Bit 0 is 0 for success and 1 for failure.
- R2: A store-conditional that holds the reservation but receives exokay = 0 in its data phase returns 1. A success (0) is only ever reported together with exokay = 1.
- R3: A store-conditional with no earlier load-reserved has st_en = 0 and returns 1.
- R4: A load-reserved followed in the very next cycle by a store-conditional to the same word gives st_en = 1. With exokay = 1 the store-conditional returns 0.
- R5: A load-reserved, one idle cycle, then a store-conditional to the same word also succeeds (st_en = 1, result 0).
- R6: A plain store of the hart between the load-reserved and the store-conditional leaves the reservation intact, and the store-conditional still succeeds.
- R7: A snoop store from another hart to the reserved word clears the reservation. A snoop to any other word leaves it intact.
- R8: A load-reserved whose data phase faults sets no reservation. The following store-conditional has st_en = 0 and returns 1, and it ignores the fault and exokay inputs in its own data phase.
- R9: A store-conditional that was enabled and whose data phase faults gives wb_valid = 0, so the destination is not overwritten.
- R10: Every store-conditional, whether it succeeds or fails, clears the reservation. A second store-conditional without a new load-reserved has st_en = 0 and returns 1.
- R11: A store-conditional to a word other than the reserved one has st_en = 0 and returns 1.
- R12: After reset the reservation is invalid and wb_valid is 0.
- R13: Op code encoding is 0 none, 1 load-reserved, 2 store-conditional, 3 plain store. A plain store always has st_en = 1, and a load-reserved or no-op always has st_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Address-phase operation (0 none, 1 LR, 2 SC, 3 store) |
| op_addr | input | 32 | Byte address of the operation |
| rsp_exokay | input | 1 | Data-phase exclusive-okay from the global monitor |
| rsp_fault | input | 1 | Data-phase bus fault |
| snoop_valid | input | 1 | Another hart stored this cycle |
| snoop_addr | input | 32 | Byte address of that remote store |
| st_en | output | 1 | Address-phase store enable |
| wb_valid | output | 1 | Data-phase write-back of an SC status word |
| wb_data | output | 32 | SC status word (0 success, 1 failure) |

## Verification
The bench targets the hand-over cases between phases. These are a store-conditional straight after its load-reserved, a store-conditional straight after another store-conditional, a snoop that lands in the same cycle as a pending check, and a faulting load-reserved whose bypass must not fire. A design without the bypass would fail the back-to-back pair. A design that clears late would let a second store-conditional succeed. A design that ignored the fault would enable a store with no reservation. Checks of the full 32-bit status word catch an inverted polarity or stray upper bits. A random phase against a bench model covers mixed interleavings of own stores and snoops.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    localparam int XLEN     = 32;
    localparam int ADDR_W   = 32;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = ADDR_W - WORD_LSB;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LR   = 2'd1,
        OP_SC   = 2'd2,
        OP_ST   = 2'd3
    } op_e;

    typedef logic [WORD_W-1:0] word_t;

    // Operation carried from address phase into data phase
    typedef struct packed {
        op_e   kind;
        logic  hit;
        word_t word;
    } dph_t;

    function automatic word_t word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WORD_LSB];
    endfunction
endpackage

// File: rtl/lrsc_resv.sv
module lrsc_resv
    import lrsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_en,
    input  word_t set_word,
    input  logic  clr_en,
    output logic  valid,
    output word_t word
);
    // Setting has priority over clearing in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (set_en) begin
            valid <= 1'b1;
            word  <= set_word;
        end else if (clr_en) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_dph.sv
module lrsc_dph
    import lrsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dph_t aph,
    output dph_t dph
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dph <= '{kind: OP_NONE, hit: 1'b0, word: '0};
        end else begin
            dph <= aph;
        end
    end
endmodule

// File: rtl/lrsc_result.sv
module lrsc_result
    import lrsc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  dph_t         dph,
    input  logic         exokay,
    input  logic         fault,
    output logic         wb_valid,
    output logic [W-1:0] wb_data
);
    logic ok;

    always_comb begin
        ok       = dph.hit && exokay;
        // A suppressed SC issued no bus access, so its response is ignored.
        wb_valid = (dph.kind == OP_SC) && !(dph.hit && fault);
        wb_data  = '0;
        wb_data[0] = !ok;
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic          rsp_exokay,
    input  logic          rsp_fault,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          st_en,
    output logic          wb_valid,
    output logic [DW-1:0] wb_data
);
    op_e   kind;
    word_t a_word;
    word_t s_word;
    dph_t  aph;
    dph_t  dph;
    logic  r_valid;
    word_t r_word;
    logic  lr_done;
    logic  sc_done;
    logic  snoop_kill;
    logic  hit;

    assign kind   = op_e'(op_kind);
    assign a_word = word_of(op_addr);
    assign s_word = word_of(snoop_addr);

    // Data-phase events that change the reservation at the end of this cycle
    assign lr_done    = (dph.kind == OP_LR) && !rsp_fault;
    assign sc_done    = (dph.kind == OP_SC);
    assign snoop_kill = snoop_valid && r_valid && (s_word == r_word);

    // Reservation as it will stand after this cycle, seen early by the SC
    always_comb begin
        if (lr_done)
            hit = (dph.word == a_word);
        else
            hit = r_valid && (r_word == a_word) && !sc_done && !snoop_kill;
    end

    always_comb begin
        aph.kind = kind;
        aph.word = a_word;
        aph.hit  = (kind == OP_SC) && hit;
        st_en    = (kind == OP_ST) || aph.hit;
    end

    lrsc_resv u_resv (
        .clk      (clk),
        .rst      (rst),
        .set_en   (lr_done),
        .set_word (dph.word),
        .clr_en   (sc_done || snoop_kill),
        .valid    (r_valid),
        .word     (r_word)
    );

    lrsc_dph u_dph (
        .clk (clk),
        .rst (rst),
        .aph (aph),
        .dph (dph)
    );

    lrsc_result #(.W(DW)) u_res (
        .dph      (dph),
        .exokay   (rsp_exokay),
        .fault    (rsp_fault),
        .wb_valid (wb_valid),
        .wb_data  (wb_data)
    );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    op_kind,
    input logic          rsp_exokay,
    input logic          rsp_fault,
    input logic          st_en,
    input logic          wb_valid,
    input logic [DW-1:0] wb_data
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_data[DW-1:1] == '0));

    assert_success_exokay_R2: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_data[0]) |-> rsp_exokay);

    assert_blocked_sc_fails_R3: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd2 && !st_en) |=> (wb_valid && wb_data[0]));

    assert_fault_no_wb_R9: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd2 && st_en) |=> (!rsp_fault || !wb_valid));

    assert_sc_after_sc_R10: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd2) |=> !(op_kind == 2'd2 && st_en));

    assert_store_enable_R13: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd3) |-> st_en);

    assert_lr_no_store_R13: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd1 || op_kind == 2'd0) |-> !st_en);

    assert_reset_idle_R12: assert property (@(posedge clk)
        $past(rst) |-> !wb_valid);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_kind    (op_kind),
    .rsp_exokay (rsp_exokay),
    .rsp_fault  (rsp_fault),
    .st_en      (st_en),
    .wb_valid   (wb_valid),
    .wb_data    (wb_data)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
    import lrsc_pkg::*;

    localparam int PERIOD = 10;
    localparam logic [31:0] A = 32'h0000_0100;
    localparam logic [31:0] B = 32'h0000_0104;
    localparam logic [31:0] C = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_kind = 2'd0;
    logic [31:0] op_addr = '0;
    logic        rsp_exokay = 1'b0;
    logic        rsp_fault = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        st_en;
    logic        wb_valid;
    logic [31:0] wb_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench model of the reservation and of the previous operation
    bit          m_valid = 1'b0;
    logic [29:0] m_word = '0;
    op_e         p_kind = OP_NONE;
    logic [29:0] p_word = '0;
    bit          p_hit = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lrsc_monitor u0 (
        .clk(clk), .rst(rst), .op_kind(op_kind), .op_addr(op_addr),
        .rsp_exokay(rsp_exokay), .rsp_fault(rsp_fault),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .st_en(st_en), .wb_valid(wb_valid), .wb_data(wb_data)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(input op_e k, input logic [29:0] w,
                                   input bit flt, input bit sv, input logic [29:0] sw);
        if (k != OP_SC) return 1'b0;
        if (p_kind == OP_LR && !flt) return (p_word == w);
        return m_valid && (m_word == w) && (p_kind != OP_SC)
               && !(sv && sw == m_word);
    endfunction

    // One cycle: drive the op, the data-phase response of the previous op and a snoop
    task automatic step(input op_e k, input logic [31:0] a, input bit exok,
                        input bit flt, input bit sv, input logic [31:0] sa,
                        input string tag);
        logic [29:0] w;
        logic [29:0] sw;
        bit h;
        w  = a[31:2];
        sw = sa[31:2];
        @(negedge clk);
        op_kind = k; op_addr = a; rsp_exokay = exok; rsp_fault = flt;
        snoop_valid = sv; snoop_addr = sa;
        #1;
        h = exp_hit(k, w, flt, sv, sw);
        check(tag, "st_en", {31'd0, st_en}, {31'd0, (k == OP_ST) || h});
        if (p_kind == OP_SC) begin
            check(tag, "wb_valid", {31'd0, wb_valid}, {31'd0, !(p_hit && flt)});
            if (!(p_hit && flt))
                check(tag, "wb_data", wb_data, (p_hit && exok) ? 32'd0 : 32'd1);
        end else begin
            check(tag, "wb_valid idle", {31'd0, wb_valid}, 32'd0);
        end
        @(posedge clk);
        if (p_kind == OP_LR && !flt) begin
            m_valid = 1'b1; m_word = p_word;
        end else if (p_kind == OP_SC || (sv && m_valid && sw == m_word)) begin
            m_valid = 1'b0;
        end
        p_kind = k; p_word = w; p_hit = h;
    endtask

    task automatic idle(input string tag);
        step(OP_NONE, 32'd0, 1'b1, 1'b0, 1'b0, 32'd0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R12", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
        check("R12", "st_en after reset", {31'd0, st_en}, 32'd0);
        // R3: SC with no reservation
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R3");
        idle("R3");
        // R4: back-to-back LR -> SC
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R13");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R4");
        idle("R4");
        // R5: one unrelated cycle between
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R5");
        idle("R5");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R5");
        idle("R5");
        // R6: own plain store to another word
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R6");
        step(OP_ST, B, 1'b1, 1'b0, 1'b0, 0, "R6");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R6");
        idle("R6");
        // R2 then R10: exokay refused, then repeated SC
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R2");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R2");
        step(OP_SC, A, 1'b0, 1'b0, 1'b0, 0, "R10");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R10");
        idle("R10");
        // R7: snoop to the reserved word, then to another word
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R7");
        idle("R7");
        step(OP_NONE, 0, 1'b1, 1'b0, 1'b1, A, "R7");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R7");
        idle("R7");
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R7");
        idle("R7");
        step(OP_NONE, 0, 1'b1, 1'b0, 1'b1, C, "R7");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R7");
        idle("R7");
        // R8: faulting LR, the suppressed SC ignores its own response
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R8");
        step(OP_SC, A, 1'b1, 1'b1, 1'b0, 0, "R8");
        step(OP_NONE, 0, 1'b1, 1'b1, 1'b0, 0, "R8");
        // R9: SC faults
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R9");
        step(OP_SC, A, 1'b1, 1'b0, 1'b0, 0, "R9");
        step(OP_NONE, 0, 1'b1, 1'b1, 1'b0, 0, "R9");
        // R11: SC to another word
        step(OP_LR, A, 1'b1, 1'b0, 1'b0, 0, "R11");
        idle("R11");
        step(OP_SC, B, 1'b1, 1'b0, 1'b0, 0, "R11");
        idle("R11");
        // Random mix, checked against the model (R1 via full word compare)
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pick[3];
            op_e k;
            pick[0] = A; pick[1] = B; pick[2] = C;
            k = op_e'($urandom_range(0, 3));
            step(k, pick[$urandom_range(0, 2)], ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0),
                 pick[$urandom_range(0, 2)], "R1");
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule